// File: doc/BRIEF.md
# ADC Output Code Formatter

This block sits between a converter core and the output pin drivers. Each cycle in which a new conversion result arrives, it works out the word that should go on the output data pins. The result first has a small signed correction added to it. The sum is clamped to the code range, and then encoded in one of two number formats. A test-pattern selector can instead replace the data with one of several fixed or generated words, so that a receiving device can check its capture path without a defined analog input.

The result comes in as an unsigned offset-binary word. Offset binary puts negative full scale at all-zeros, mid-scale at only the most significant bit set, and positive full scale at all-ones. The two's-complement format is the same code with the most significant bit inverted. The formatted word is registered, so it appears one clock after its sample, together with a valid strobe. The reset is asynchronous, active low, and released in step with the clock.

Top module: `adc_code_formatter`

## Requirements
- R1: While reset is held and after it is released, before any valid sample, `out_data` is 0x0000 and `out_valid` is 0.
- R2: `out_valid` equals the previous cycle's `smp_valid`. `out_data` is updated only one cycle after a cycle in which `smp_valid` is 1. In any other cycle it keeps its value, whatever the other inputs do.
- R3: With `pat_sel` = 000 and `twos_comp` = 0, the output is `smp_data` plus `ofs_val`. `ofs_val` is read as a signed two's-complement value from -32 to +31.
- R4: When that sum falls below 0 it is clamped to 0x0000. When it exceeds 0xFFFF it is clamped to 0xFFFF.
- R5: With `twos_comp` = 1, the clamped sum is output with its most significant bit inverted. The end codes are then 0x8000 at the bottom and 0x7FFF at the top.
- R6: The select codes 110 and 111 behave exactly like 000, so normal data is output.
- R7: `pat_sel` = 001 outputs 0x0000 and `pat_sel` = 010 outputs 0xFFFF.
- R8: `pat_sel` = 011 outputs 0xAAAA when an even number of valid samples have been taken since reset, and 0x5555 when that number is odd. The count does not include the current sample.
- R9: `pat_sel` = 100 outputs a ramp. Its value is the number of valid samples taken since reset, not counting the current one, modulo 65536. The count advances on every valid sample, whatever the select.
- R10: `pat_sel` = 101 outputs `pat_user`. Every test pattern (codes 001 to 101) ignores `smp_data`, `ofs_val` and `twos_comp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 16 | Converter result, offset binary |
| smp_valid | input | 1 | Marks a cycle that carries a new result |
| ofs_val | input | 6 | Signed digital offset added to the result |
| twos_comp | input | 1 | 1 selects two's-complement output coding |
| pat_sel | input | 3 | Output source: data or test pattern |
| pat_user | input | 16 | User-defined test word |
| out_data | output | 16 | Formatted output word |
| out_valid | output | 1 | Marks a cycle with a newly formatted word |

## Verification
The assertions check on every cycle the properties that can be stated locally. These are the one-cycle valid alignment and the hold of the output between samples. They also cover pass-through when no offset is applied, the inversion of the most significant bit in two's-complement mode, the clamp at both ends for extreme inputs, and the fixed and user pattern words. The bench alone can show the properties that depend on history or arithmetic over the whole range. These include the exact sum for every offset value against a set of samples chosen near both code limits and near mid-scale. They also include the alternating phase and the ramp value, both of which depend on the count of past samples, the ramp wrapping past 65535, and the fact that idle cycles do not advance either pattern.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef enum logic [2:0] {
    PAT_DATA = 3'b000,
    PAT_ZERO = 3'b001,
    PAT_ONES = 3'b010,
    PAT_ALT  = 3'b011,
    PAT_RAMP = 3'b100,
    PAT_USER = 3'b101
  } pat_sel_e;

  localparam int SEL_W = 3;

endpackage

// File: rtl/fmt_rst_sync.sv
module fmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fmt_offset_sat.sv
module fmt_offset_sat #(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 6
) (
  input  logic [DATA_W-1:0] smp_data,
  input  logic [OFS_W-1:0]  ofs_val,
  output logic [DATA_W-1:0] sat_data
);

  localparam int SUM_W = DATA_W + 2;

  logic [SUM_W-1:0] ofs_ext;
  logic [SUM_W-1:0] sum;
  logic             under;
  logic             over;

  always_comb begin
    ofs_ext = {{(SUM_W-OFS_W){ofs_val[OFS_W-1]}}, ofs_val};
    sum     = {2'b00, smp_data} + ofs_ext;
    under   = sum[SUM_W-1];
    over    = !under && sum[DATA_W];
    if (under) begin
      sat_data = '0;
    end else if (over) begin
      sat_data = '1;
    end else begin
      sat_data = sum[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/fmt_coder.sv
module fmt_coder #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] bin_data,
  input  logic              twos_comp,
  output logic [DATA_W-1:0] coded_data
);

  always_comb begin
    coded_data = bin_data;
    if (twos_comp) begin
      coded_data[DATA_W-1] = ~bin_data[DATA_W-1];
    end
  end

endmodule

// File: rtl/fmt_pattern_gen.sv
module fmt_pattern_gen
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [SEL_W-1:0]  pat_sel,
  input  logic [DATA_W-1:0] pat_user,
  output logic [DATA_W-1:0] pat_word,
  output logic              pat_active
);

  logic [DATA_W-1:0] ramp_q;
  logic [DATA_W-1:0] ramp_d;
  logic [DATA_W-1:0] alt_hi;
  logic [DATA_W-1:0] alt_lo;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_alt
    assign alt_hi[gi] = ((gi % 2) == 1);
    assign alt_lo[gi] = ((gi % 2) == 0);
  end

  always_comb begin
    ramp_d = ramp_q;
    if (adv) begin
      ramp_d = ramp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
    end else begin
      ramp_q <= ramp_d;
    end
  end

  always_comb begin
    pat_active = 1'b1;
    case (pat_sel)
      PAT_ZERO: pat_word = '0;
      PAT_ONES: pat_word = '1;
      PAT_ALT:  pat_word = ramp_q[0] ? alt_lo : alt_hi;
      PAT_RAMP: pat_word = ramp_q;
      PAT_USER: pat_word = pat_user;
      default: begin
        pat_word   = '0;
        pat_active = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/adc_code_formatter.sv
module adc_code_formatter
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_valid,
  input  logic [OFS_W-1:0]  ofs_val,
  input  logic              twos_comp,
  input  logic [SEL_W-1:0]  pat_sel,
  input  logic [DATA_W-1:0] pat_user,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  logic              rst_sync_n;
  logic [DATA_W-1:0] sat_data;
  logic [DATA_W-1:0] coded_data;
  logic [DATA_W-1:0] pat_word;
  logic              pat_active;
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  fmt_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fmt_offset_sat #(.DATA_W(DATA_W), .OFS_W(OFS_W)) i_offset_sat (
    .smp_data (smp_data),
    .ofs_val  (ofs_val),
    .sat_data (sat_data)
  );

  fmt_coder #(.DATA_W(DATA_W)) i_coder (
    .bin_data   (sat_data),
    .twos_comp  (twos_comp),
    .coded_data (coded_data)
  );

  fmt_pattern_gen #(.DATA_W(DATA_W)) i_pattern_gen (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .adv        (smp_valid),
    .pat_sel    (pat_sel),
    .pat_user   (pat_user),
    .pat_word   (pat_word),
    .pat_active (pat_active)
  );

  always_comb begin
    data_d = data_q;
    if (smp_valid) begin
      data_d = pat_active ? pat_word : coded_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= smp_valid;
    end
  end

  assign out_data  = data_q;
  assign out_valid = valid_q;

endmodule

// File: rtl/adc_code_formatter_chk.sv
module adc_code_formatter_chk
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 6
) (
  input logic              clk,
  input logic              rst_i,
  input logic [DATA_W-1:0] smp_data,
  input logic              smp_valid,
  input logic [OFS_W-1:0]  ofs_val,
  input logic              twos_comp,
  input logic [SEL_W-1:0]  pat_sel,
  input logic [DATA_W-1:0] pat_user,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid
);

  localparam logic [DATA_W-1:0] MAXC = '1;
  localparam logic [DATA_W-1:0] MINC = '0;

  logic [DATA_W-1:0] alt_a;
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_alt
    assign alt_a[gi] = ((gi % 2) == 1);
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_i)
    smp_valid |=> out_valid);

  assert_valid_low_R2: assert property (@(posedge clk) disable iff (!rst_i)
    !smp_valid |=> !out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_i)
    !smp_valid |=> $stable(out_data));

  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (smp_valid && pat_sel == PAT_DATA && ofs_val == '0 && !twos_comp)
      |=> out_data == $past(smp_data));

  assert_twos_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (smp_valid && pat_sel == PAT_DATA && ofs_val == '0 && twos_comp)
      |=> out_data == {~$past(smp_data[DATA_W-1]), $past(smp_data[DATA_W-2:0])});

  assert_sat_hi_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (smp_valid && pat_sel == PAT_DATA && !twos_comp && smp_data == MAXC
      && !ofs_val[OFS_W-1]) |=> out_data == MAXC);

  assert_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (smp_valid && pat_sel == PAT_DATA && !twos_comp && smp_data == MINC
      && ofs_val[OFS_W-1]) |=> out_data == MINC);

  assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (smp_valid && pat_sel == PAT_ZERO) |=> out_data == MINC);

  assert_ones_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (smp_valid && pat_sel == PAT_ONES) |=> out_data == MAXC);

  assert_alt_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (smp_valid && pat_sel == PAT_ALT) |=> (out_data == alt_a || out_data == ~alt_a));

  assert_user_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (smp_valid && pat_sel == PAT_USER) |=> out_data == $past(pat_user));

endmodule

bind adc_code_formatter adc_code_formatter_chk #(
  .DATA_W(DATA_W),
  .OFS_W (OFS_W)
) i_chk (
  .clk       (clk),
  .rst_i     (rst_sync_n),
  .smp_data  (smp_data),
  .smp_valid (smp_valid),
  .ofs_val   (ofs_val),
  .twos_comp (twos_comp),
  .pat_sel   (pat_sel),
  .pat_user  (pat_user),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/test_adc_code_formatter.sv
module test_adc_code_formatter;

  localparam int DW = 16;
  localparam int OW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] smp_data;
  logic          smp_valid;
  logic [OW-1:0] ofs_val;
  logic          twos_comp;
  logic [2:0]    pat_sel;
  logic [DW-1:0] pat_user;
  logic [DW-1:0] out_data;
  logic          out_valid;

  int            n_tests = 0;
  int            n_fail  = 0;
  int            vcount  = 0;
  logic [DW-1:0] last_exp = '0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  adc_code_formatter #(.DATA_W(DW), .OFS_W(OW)) i_adc_code_formatter (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_data  (smp_data),
    .smp_valid (smp_valid),
    .ofs_val   (ofs_val),
    .twos_comp (twos_comp),
    .pat_sel   (pat_sel),
    .pat_user  (pat_user),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  task automatic check16(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_norm(int s, int oraw, bit tc);
    int o = (oraw >= 32) ? oraw - 64 : oraw;
    int v = s + o;
    if (v < 0) v = 0;
    if (v > 65535) v = 65535;
    if (tc) v = v ^ 32'h8000;
    return DW'(v);
  endfunction

  function automatic logic [DW-1:0] model(int sel, int s, int oraw, bit tc,
                                          logic [DW-1:0] user, int cnt);
    case (sel)
      1: return 16'h0000;
      2: return 16'hFFFF;
      3: return (cnt % 2 == 1) ? 16'h5555 : 16'hAAAA;
      4: return DW'(cnt);
      5: return user;
      default: return model_norm(s, oraw, tc);
    endcase
  endfunction

  // called at a negedge; returns at the next negedge after checking
  task automatic apply(int s, int o, bit tc, int sel, logic [DW-1:0] user, string req);
    logic [DW-1:0] exp;
    smp_data  = DW'(s);
    ofs_val   = OW'(o);
    twos_comp = tc;
    pat_sel   = 3'(sel);
    pat_user  = user;
    smp_valid = 1'b1;
    exp = model(sel, s, o, tc, user, vcount);
    @(negedge clk);
    check16(req, out_data, exp);
    check1({req, " valid"}, out_valid, 1'b1);
    vcount++;
    last_exp = exp;
  endtask

  task automatic idle(int s, int o, int sel);
    smp_valid = 1'b0;
    smp_data  = DW'(s);
    ofs_val   = OW'(o);
    pat_sel   = 3'(sel);
    twos_comp = ~twos_comp;
    pat_user  = ~pat_user;
    @(negedge clk);
    check16("R2 hold", out_data, last_exp);
    check1("R2 valid low", out_valid, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int smp_list[12] = '{0, 1, 31, 32, 100, 32767, 32768, 32769,
                         65503, 65504, 65534, 65535};
    int sels[3] = '{0, 6, 7};
    rst_n     = 1'b0;
    smp_data  = '0;
    smp_valid = 1'b0;
    ofs_val   = '0;
    twos_comp = 1'b0;
    pat_sel   = '0;
    pat_user  = 16'h1234;
    repeat (3) @(negedge clk);
    check16("R1 data in reset", out_data, 16'h0000);
    check1("R1 valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check16("R1 data after reset", out_data, 16'h0000);
    check1("R1 valid after reset", out_valid, 1'b0);

    // offset, clamp and coding sweep over all offsets
    foreach (sels[k]) begin
      for (int si = 0; si < 12; si++) begin
        for (int o = 0; o < 64; o++) begin
          for (int tc = 0; tc < 2; tc++) begin
            string req;
            if (sels[k] != 0) req = "R6 reserved code";
            else if (tc == 1) req = "R5 twos complement";
            else req = "R3 R4 offset clamp";
            apply(smp_list[si], o, tc[0], sels[k], 16'h0F0F, req);
          end
        end
      end
      idle(smp_list[k], 17, 5);
    end

    // test patterns with varied data, offset and coding
    for (int sel = 1; sel <= 5; sel++) begin
      for (int i = 0; i < 40; i++) begin
        string req;
        case (sel)
          1, 2: req = "R7 fixed pattern";
          3: req = "R8 alternating";
          4: req = "R9 ramp";
          default: req = "R10 user pattern";
        endcase
        apply(i * 1637, (i * 7) % 64, i[0], sel, DW'(i * 40503 + 3), req);
        if (i % 9 == 4) idle(i * 11, 63, 0);
      end
    end

    // ramp through its wrap point
    while (vcount < 65540) begin
      apply(vcount, 5, 1'b0, 4, 16'h0000, "R9 ramp wrap");
    end
    idle(12, 3, 4);
    apply(0, 0, 1'b0, 3, 16'h0000, "R8 alternating after idle");
    apply(0, 0, 1'b0, 4, 16'h0000, "R9 ramp after idle");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule